// File: doc/BRIEF.md
# DMA Debug Command and Interrupt Port

This block is the host-facing front end of a DMA engine. Over a word-addressed register bus the host loads a single instruction into a two-word mailbox and then triggers it. The block hands that instruction to the engine's instruction executor through a thread-select, opcode and operand interface. A busy flag stays set until the executor reports that it has finished, and the mailbox is locked for that whole time.

The same register window collects what the engine reports back. Program-issued events set pending bits, and an enable mask routes them to a level-sensitive interrupt line. The host clears pending bits by writing ones. Fault reports from the manager thread and from each of the eight channel threads are captured as sticky type words. A per-channel summary word shows which channels have faulted. An abort line stays high while any fault bit is held. The instruction executor itself lives outside this block.

Top module: `dma_dbg_port`

## Requirements
- R1: After reset the busy flag, both mailbox words, the event enable and pending words and every fault word read 0, and `cmd_go`, `cmd_start`, `cmd_kill`, `irq` and `abort` are low.
- R2: Word address 1 holds the first instruction word. Only bits [31:16] (opcode field, opcode byte in [23:16]), [10:8] (channel number) and bit 0 (1 = channel thread, 0 = manager thread) are kept; all other bits read 0. Word address 2 holds the full 32-bit operand. Both read back as stored and drive `cmd_op`, `cmd_chan`, `cmd_chan_thread` and `cmd_operand`.
- R3: Writing 0 to word address 3 while idle raises `cmd_go` for exactly one cycle, in the cycle after the write. Bit 0 of word address 0 reads 1 from that cycle until the cycle after `exe_done` is seen. Writing any nonzero value to address 3 does nothing.
- R4: While busy, writes to addresses 1, 2 and 3 are ignored: the held instruction is unchanged and no new `cmd_go` is issued.
- R5: `cmd_start` pulses with `cmd_go` when the held thread is the manager and the opcode byte is 0xA0. `cmd_kill` pulses with `cmd_go` when the held thread is a channel and the opcode byte is 0x01.
- R6: Each `evt_in` pulse sets the matching pending bit (address 5). Address 4 is the enable mask. Address 6 reads pending AND enable. `irq` is high whenever that masked word is nonzero and stays high until the bits are cleared.
- R7: Writing to address 7 clears each pending bit written as 1, so all ones drops every event. An event arriving in the same cycle as a clear stays pending.
- R8: A manager fault report ORs its code, limited to bits 0, 1, 4, 5, 16 and 30, into address 8. A report with no such bit is ignored. If a manager-thread instruction is busy when a report is captured, bit 30 is also set.
- R9: A channel fault report for channel n ORs its code, limited to bits 0, 1, 4, 5, 12, 13, 16, 17, 18, 30 and 31, into address 16+n, and bit n of address 9 reads 1 once that word is nonzero. Bit 30 is added when a channel-thread instruction for that same channel is busy.
- R10: `abort` is high in the cycle after any fault bit is captured and stays high until reset.
- R11: Reads of addresses 3, 7, 10 to 15 and 24 to 31 return 0, and a read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high, else 0 |
| cmd_go | output | 1 | One-cycle launch of the held instruction |
| cmd_chan_thread | output | 1 | 1 = channel thread, 0 = manager thread |
| cmd_chan | output | 3 | Target channel number |
| cmd_op | output | 16 | Instruction bytes |
| cmd_operand | output | 32 | Operand word |
| cmd_start | output | 1 | Launch decoded as a channel start |
| cmd_kill | output | 1 | Launch decoded as a channel kill |
| exe_done | input | 1 | Executor finished the injected instruction |
| evt_in | input | 8 | Event pulses from the engine |
| mgr_flt_vld | input | 1 | Manager fault report strobe |
| mgr_flt_code | input | 32 | Manager fault type bits |
| chan_flt_vld | input | 1 | Channel fault report strobe |
| chan_flt_id | input | 3 | Faulting channel |
| chan_flt_code | input | 32 | Channel fault type bits |
| irq | output | 1 | Level interrupt |
| abort | output | 1 | Sticky fault indication |

## Verification
The bench sweeps every opcode byte on both threads. A decoder that ignored the thread bit, or that compared the wrong byte, would then pulse start or kill on the wrong launches. It retries the mailbox writes and the trigger while busy, which exposes a lock that lets a late write corrupt the instruction or relaunch it. All 256 enable masks are run against varied pending patterns, including a clear that lands on an arriving event. Losing that event or routing the wrong bit would show in the masked word or the interrupt. Every fault bit of every channel is injected in turn, with the debug flag probed on a matching and a non-matching channel. Keeping illegal bits, or forgetting to keep abort set, would leave the accumulated words wrong.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'd0;
  localparam logic [ADDR_W-1:0] A_INSA  = 5'd1;
  localparam logic [ADDR_W-1:0] A_INSB  = 5'd2;
  localparam logic [ADDR_W-1:0] A_GO    = 5'd3;
  localparam logic [ADDR_W-1:0] A_EVEN  = 5'd4;
  localparam logic [ADDR_W-1:0] A_EVRAW = 5'd5;
  localparam logic [ADDR_W-1:0] A_EVMSK = 5'd6;
  localparam logic [ADDR_W-1:0] A_EVCLR = 5'd7;
  localparam logic [ADDR_W-1:0] A_MFLT  = 5'd8;
  localparam logic [ADDR_W-1:0] A_CMAP  = 5'd9;
  localparam int unsigned CFLT_BASE = 16;

  localparam logic [31:0] INSA_KEEP    = 32'hFFFF_0701;
  localparam logic [31:0] MGR_FLT_MASK = 32'h4001_0033;
  localparam logic [31:0] CH_FLT_MASK  = 32'hC007_3033;
  localparam int unsigned DBG_BIT      = 30;
  localparam logic [7:0]  OP_START     = 8'hA0;
  localparam logic [7:0]  OP_KILL      = 8'h01;
endpackage

// File: rtl/dbgp_mailbox.sv
module dbgp_mailbox
  import dbgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_insa,
  input  logic        wr_insb,
  input  logic        wr_go,
  input  logic [31:0] wdata,
  input  logic        exe_done,
  output logic        busy,
  output logic [31:0] insa,
  output logic [31:0] insb,
  output logic        go,
  output logic        start,
  output logic        kill
);
  logic        busy_q, busy_d;
  logic [31:0] insa_q, insa_d, insb_q, insb_d;
  logic        go_q, go_d, start_q, start_d, kill_q, kill_d;
  logic        launch;

  assign launch = !busy_q && wr_go && (wdata == '0);

  always_comb begin
    busy_d  = busy_q;
    insa_d  = insa_q;
    insb_d  = insb_q;
    go_d    = launch;
    start_d = launch && !insa_q[0] && (insa_q[23:16] == OP_START);
    kill_d  = launch &&  insa_q[0] && (insa_q[23:16] == OP_KILL);
    if (!busy_q) begin
      if (wr_insa) insa_d = wdata & INSA_KEEP;
      if (wr_insb) insb_d = wdata;
      if (launch)  busy_d = 1'b1;
    end else if (exe_done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      insa_q  <= '0;
      insb_q  <= '0;
      go_q    <= 1'b0;
      start_q <= 1'b0;
      kill_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      go_q    <= go_d;
      start_q <= start_d;
      kill_q  <= kill_d;
      if (!busy_q && wr_insa) insa_q <= insa_d;
      if (!busy_q && wr_insb) insb_q <= insb_d;
    end
  end

  assign busy  = busy_q;
  assign insa  = insa_q;
  assign insb  = insb_q;
  assign go    = go_q;
  assign start = start_q;
  assign kill  = kill_q;
endmodule

// File: rtl/dbgp_events.sv
module dbgp_events #(
  parameter int unsigned NEVT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt_in,
  input  logic            wr_en,
  input  logic            wr_clr,
  input  logic [NEVT-1:0] wdata,
  output logic [NEVT-1:0] en,
  output logic [NEVT-1:0] raw,
  output logic [NEVT-1:0] msk,
  output logic            irq
);
  logic [NEVT-1:0] en_q, raw_q, raw_d, clr_bits;

  assign clr_bits = wr_clr ? wdata : '0;

  always_comb begin
    raw_d = (raw_q & ~clr_bits) | evt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      raw_q <= '0;
    end else begin
      if (wr_en) en_q <= wdata;
      raw_q <= raw_d;
    end
  end

  assign en  = en_q;
  assign raw = raw_q;
  assign msk = raw_q & en_q;
  assign irq = |msk;
endmodule

// File: rtl/dbgp_faults.sv
module dbgp_faults
  import dbgp_pkg::*;
#(
  parameter int unsigned NCHAN = 8,
  localparam int unsigned CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   busy,
  input  logic                   held_chan_thread,
  input  logic [CH_W-1:0]        held_chan,
  input  logic                   mgr_vld,
  input  logic [31:0]            mgr_code,
  input  logic                   ch_vld,
  input  logic [CH_W-1:0]        ch_id,
  input  logic [31:0]            ch_code,
  output logic [31:0]            mgr_type,
  output logic [NCHAN-1:0][31:0] ch_type,
  output logic [NCHAN-1:0]       ch_map,
  output logic                   abort
);
  logic [31:0] mgr_q, mgr_d;
  logic        mgr_hit;

  assign mgr_hit = mgr_vld && |(mgr_code & MGR_FLT_MASK);

  always_comb begin
    mgr_d = mgr_q | (mgr_code & MGR_FLT_MASK);
    if (busy && !held_chan_thread) mgr_d[DBG_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mgr_q <= '0;
    else if (mgr_hit) mgr_q <= mgr_d;
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    logic [31:0] typ_q, typ_d;
    logic        hit;

    assign hit = ch_vld && (ch_id == CH_W'(c)) && |(ch_code & CH_FLT_MASK);

    always_comb begin
      typ_d = typ_q | (ch_code & CH_FLT_MASK);
      if (busy && held_chan_thread && (held_chan == CH_W'(c))) typ_d[DBG_BIT] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   typ_q <= '0;
      else if (hit) typ_q <= typ_d;
    end

    assign ch_type[c] = typ_q;
    assign ch_map[c]  = |typ_q;
  end

  assign mgr_type = mgr_q;
  assign abort    = (|mgr_q) || (|ch_map);
endmodule

// File: rtl/dma_dbg_port.sv
module dma_dbg_port
  import dbgp_pkg::*;
#(
  parameter int unsigned NCHAN = 8,
  parameter int unsigned NEVT  = 8,
  localparam int unsigned CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cmd_go,
  output logic              cmd_chan_thread,
  output logic [CH_W-1:0]   cmd_chan,
  output logic [15:0]       cmd_op,
  output logic [31:0]       cmd_operand,
  output logic              cmd_start,
  output logic              cmd_kill,
  input  logic              exe_done,
  input  logic [NEVT-1:0]   evt_in,
  input  logic              mgr_flt_vld,
  input  logic [31:0]       mgr_flt_code,
  input  logic              chan_flt_vld,
  input  logic [CH_W-1:0]   chan_flt_id,
  input  logic [31:0]       chan_flt_code,
  output logic              irq,
  output logic              abort
);
  logic                   rst_m, rst_q;
  logic                   busy;
  logic [31:0]            insa, insb, mgr_type;
  logic [NEVT-1:0]        evt_en, evt_raw, evt_msk;
  logic [NCHAN-1:0][31:0] ch_type;
  logic [NCHAN-1:0]       ch_map;
  logic [31:0]            rdata_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  dbgp_mailbox u_mbox (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_insa  (bus_wr && (bus_addr == A_INSA)),
    .wr_insb  (bus_wr && (bus_addr == A_INSB)),
    .wr_go    (bus_wr && (bus_addr == A_GO)),
    .wdata    (bus_wdata),
    .exe_done (exe_done),
    .busy     (busy),
    .insa     (insa),
    .insb     (insb),
    .go       (cmd_go),
    .start    (cmd_start),
    .kill     (cmd_kill)
  );

  assign cmd_op          = insa[31:16];
  assign cmd_chan        = insa[8 +: CH_W];
  assign cmd_chan_thread = insa[0];
  assign cmd_operand     = insb;

  dbgp_events #(.NEVT(NEVT)) u_evt (
    .clk    (clk),
    .rst_n  (rst_q),
    .evt_in (evt_in),
    .wr_en  (bus_wr && (bus_addr == A_EVEN)),
    .wr_clr (bus_wr && (bus_addr == A_EVCLR)),
    .wdata  (bus_wdata[NEVT-1:0]),
    .en     (evt_en),
    .raw    (evt_raw),
    .msk    (evt_msk),
    .irq    (irq)
  );

  dbgp_faults #(.NCHAN(NCHAN)) u_flt (
    .clk              (clk),
    .rst_n            (rst_q),
    .busy             (busy),
    .held_chan_thread (cmd_chan_thread),
    .held_chan        (cmd_chan),
    .mgr_vld          (mgr_flt_vld),
    .mgr_code         (mgr_flt_code),
    .ch_vld           (chan_flt_vld),
    .ch_id            (chan_flt_id),
    .ch_code          (chan_flt_code),
    .mgr_type         (mgr_type),
    .ch_type          (ch_type),
    .ch_map           (ch_map),
    .abort            (abort)
  );

  always_comb begin
    rdata_c = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_STAT:  rdata_c = {31'd0, busy};
        A_INSA:  rdata_c = insa;
        A_INSB:  rdata_c = insb;
        A_EVEN:  rdata_c = 32'(evt_en);
        A_EVRAW: rdata_c = 32'(evt_raw);
        A_EVMSK: rdata_c = 32'(evt_msk);
        A_MFLT:  rdata_c = mgr_type;
        A_CMAP:  rdata_c = 32'(ch_map);
        default: rdata_c = '0;
      endcase
      for (int i = 0; i < NCHAN; i++) begin
        if (bus_addr == ADDR_W'(CFLT_BASE + i)) rdata_c = ch_type[i];
      end
    end
  end

  assign bus_rdata = rdata_c;
endmodule

// File: rtl/dbgp_checker.sv
module dbgp_checker
  import dbgp_pkg::*;
#(
  parameter int unsigned NEVT = 8
) (
  input logic              clk,
  input logic              rst_q,
  input logic              busy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              cmd_go,
  input logic              cmd_start,
  input logic              cmd_kill,
  input logic              cmd_chan_thread,
  input logic [15:0]       cmd_op,
  input logic [31:0]       cmd_operand,
  input logic [NEVT-1:0]   evt_in,
  input logic              mgr_flt_vld,
  input logic [31:0]       mgr_flt_code,
  input logic              irq,
  input logic              abort
);
  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && bus_addr == A_GO && bus_wdata == '0 && !busy) |=> (cmd_go && busy));

  p_go_single_r3: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_go |=> !cmd_go);

  p_hold_insn_r4: assert property (@(posedge clk) disable iff (!rst_q)
    busy |=> ($stable(cmd_op) && $stable(cmd_operand) && $stable(cmd_chan_thread)));

  p_no_relaunch_r4: assert property (@(posedge clk) disable iff (!rst_q)
    busy |=> !cmd_go);

  p_decode_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_start || cmd_kill) |-> (cmd_go && !(cmd_start && cmd_kill)));

  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && bus_addr == A_EVCLR && (&bus_wdata[NEVT-1:0]) && evt_in == '0) |=> !irq);

  p_mgr_capture_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (mgr_flt_vld && |(mgr_flt_code & MGR_FLT_MASK)) |=> abort);

  p_abort_sticky_r10: assert property (@(posedge clk) disable iff (!rst_q)
    abort |=> abort);
endmodule

bind dma_dbg_port dbgp_checker #(.NEVT(NEVT)) u_chk (
  .clk             (clk),
  .rst_q           (rst_q),
  .busy            (busy),
  .bus_addr        (bus_addr),
  .bus_wr          (bus_wr),
  .bus_wdata       (bus_wdata),
  .cmd_go          (cmd_go),
  .cmd_start       (cmd_start),
  .cmd_kill        (cmd_kill),
  .cmd_chan_thread (cmd_chan_thread),
  .cmd_op          (cmd_op),
  .cmd_operand     (cmd_operand),
  .evt_in          (evt_in),
  .mgr_flt_vld     (mgr_flt_vld),
  .mgr_flt_code    (mgr_flt_code),
  .irq             (irq),
  .abort           (abort)
);

// File: tb/test_dma_dbg_port.sv
`timescale 1ns/1ps
module test_dma_dbg_port;
  localparam logic [31:0] MMASK = 32'h4001_0033;
  localparam logic [31:0] CMASK = 32'hC007_3033;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmd_go, cmd_chan_thread, cmd_start, cmd_kill;
  logic [2:0]  cmd_chan;
  logic [15:0] cmd_op;
  logic [31:0] cmd_operand;
  logic        exe_done = 1'b0;
  logic [7:0]  evt_in = '0;
  logic        mgr_flt_vld = 1'b0, chan_flt_vld = 1'b0;
  logic [31:0] mgr_flt_code = '0, chan_flt_code = '0;
  logic [2:0]  chan_flt_id = '0;
  logic        irq, abort;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  dma_dbg_port i_dma_dbg_port (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); exe_done = 1'b1;
    @(negedge clk); exe_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  logic [31:0] v;
  logic [31:0] exp_m;
  logic [31:0] exp_c [8];

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(5'd0, v); chk("R1 busy", v, 0);
    rd(5'd1, v); chk("R1 insa", v, 0);
    rd(5'd5, v); chk("R1 pending", v, 0);
    rd(5'd8, v); chk("R1 mgr fault", v, 0);
    rd(5'd9, v); chk("R1 chan map", v, 0);
    chk("R1 outputs", {cmd_go, cmd_start, cmd_kill, irq, abort}, 0);

    // R2 mailbox storage and field routing
    wr(5'd1, 32'h12A0_F7FF);
    rd(5'd1, v); chk("R2 insa keep", v, 32'h12A0_0701);
    chk("R2 fields", {cmd_op, 5'd0, cmd_chan, 7'd0, cmd_chan_thread}, 32'h12A0_0701);
    wr(5'd2, 32'hDEAD_BEEF);
    rd(5'd2, v); chk("R2 insb", v, 32'hDEAD_BEEF);
    chk("R2 operand", cmd_operand, 32'hDEAD_BEEF);

    // R3 nonzero trigger ignored
    wr(5'd3, 32'h1);
    chk("R3 nonzero go", {31'd0, cmd_go}, 0);
    rd(5'd0, v); chk("R3 nonzero busy", v, 0);

    // R3 R5 sweep every opcode byte on both threads
    for (int op = 0; op < 256; op++) begin
      for (int th = 0; th < 2; th++) begin
        logic [31:0] a;
        a = {8'h5A, 8'(op), 5'd0, 3'(op % 8), 7'd0, 1'(th)};
        wr(5'd1, a);
        wr(5'd2, 32'(op * 977 + th));
        wr(5'd3, 32'h0);
        chk("R3 go pulse", {31'd0, cmd_go}, 1);
        chk("R5 start", {31'd0, cmd_start}, {31'd0, (th == 0) && (op == 8'hA0)});
        chk("R5 kill", {31'd0, cmd_kill}, {31'd0, (th == 1) && (op == 8'h01)});
        rd(5'd0, v); chk("R3 busy set", v, 1);
        chk("R3 go single", {31'd0, cmd_go}, 0);
        if (op % 32 == 0) begin
          // R4 writes while busy ignored
          wr(5'd1, 32'hFFFF_FFFF);
          wr(5'd2, 32'h0);
          wr(5'd3, 32'h0);
          chk("R4 no relaunch", {31'd0, cmd_go}, 0);
          rd(5'd1, v); chk("R4 insa held", v, a);
          rd(5'd2, v); chk("R4 insb held", v, 32'(op * 977 + th));
        end
        done_pulse();
        rd(5'd0, v); chk("R3 busy clear", v, 0);
      end
    end

    // R6 R7 all enable masks
    for (int en = 0; en < 256; en++) begin
      logic [7:0] p;
      p = 8'((en * 37 + 11) & 8'hFF);
      wr(5'd4, 32'(en));
      wr(5'd7, 32'hFFFF_FFFF);
      @(negedge clk); evt_in = p;
      @(negedge clk); evt_in = '0;
      rd(5'd5, v); chk("R6 pending", v, 32'(p));
      rd(5'd6, v); chk("R6 masked", v, 32'(p & 8'(en)));
      repeat (3) @(negedge clk);
      chk("R6 irq level", {31'd0, irq}, {31'd0, |(p & 8'(en))});
      wr(5'd7, 32'(en));
      rd(5'd5, v); chk("R7 partial clear", v, 32'(p & ~8'(en)));
      chk("R7 irq after clear", {31'd0, irq}, 0);
    end
    // R7 clear colliding with arriving event
    wr(5'd4, 32'hFF);
    @(negedge clk);
    bus_addr = 5'd7; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1; evt_in = 8'h24;
    @(negedge clk);
    bus_wr = 1'b0; evt_in = '0;
    rd(5'd5, v); chk("R7 event beats clear", v, 32'h24);
    chk("R7 irq kept", {31'd0, irq}, 1);
    wr(5'd7, 32'hFFFF_FFFF);
    rd(5'd5, v); chk("R7 clear all", v, 0);
    // R11 unmapped and write-only reads
    for (int a = 10; a < 16; a++) begin rd(5'(a), v); chk("R11 unmapped", v, 0); end
    for (int a = 24; a < 32; a++) begin rd(5'(a), v); chk("R11 unmapped", v, 0); end
    rd(5'd3, v); chk("R11 go reads 0", v, 0);
    rd(5'd7, v); chk("R11 clear reads 0", v, 0);

    // R8 R10 manager faults
    @(negedge clk); mgr_flt_vld = 1'b1; mgr_flt_code = 32'h0000_000C;
    @(negedge clk); mgr_flt_vld = 1'b0;
    rd(5'd8, v); chk("R8 illegal ignored", v, 0);
    chk("R10 no abort", {31'd0, abort}, 0);
    wr(5'd1, 32'h0000_0000);
    wr(5'd3, 32'h0);
    @(negedge clk); mgr_flt_vld = 1'b1; mgr_flt_code = 32'h0000_0002;
    @(negedge clk); mgr_flt_vld = 1'b0;
    chk("R10 abort rise", {31'd0, abort}, 1);
    rd(5'd8, v); chk("R8 debug bit", v, 32'h4000_0002);
    done_pulse();
    exp_m = 32'h4000_0002;
    for (int b = 0; b < 32; b++) begin
      @(negedge clk); mgr_flt_vld = 1'b1; mgr_flt_code = 32'h1 << b;
      @(negedge clk); mgr_flt_vld = 1'b0;
      exp_m |= (32'h1 << b) & MMASK;
      rd(5'd8, v); chk("R8 mgr accumulate", v, exp_m);
    end

    // R9 channel faults with debug flag on channel 3 only
    for (int c = 0; c < 8; c++) exp_c[c] = '0;
    wr(5'd1, 32'h0001_0301);
    wr(5'd3, 32'h0);
    @(negedge clk); chan_flt_vld = 1'b1; chan_flt_id = 3'd3; chan_flt_code = 32'h0004_0000;
    @(negedge clk); chan_flt_id = 3'd5; chan_flt_code = 32'h0002_0000;
    @(negedge clk); chan_flt_vld = 1'b0;
    done_pulse();
    exp_c[3] = 32'h4004_0000; exp_c[5] = 32'h0002_0000;
    rd(5'd19, v); chk("R9 debug chan match", v, exp_c[3]);
    rd(5'd21, v); chk("R9 debug chan other", v, exp_c[5]);
    rd(5'd9, v); chk("R9 map partial", v, 32'h28);
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < 32; b++) begin
        @(negedge clk); chan_flt_vld = 1'b1; chan_flt_id = 3'(c); chan_flt_code = 32'h1 << b;
        @(negedge clk); chan_flt_vld = 1'b0;
        exp_c[c] |= (32'h1 << b) & CMASK;
        rd(5'(16 + c), v); chk("R9 chan accumulate", v, exp_c[c]);
      end
    end
    rd(5'd9, v); chk("R9 map full", v, 32'hFF);
    repeat (10) @(negedge clk);
    chk("R10 abort sticky", {31'd0, abort}, 1);
    do_reset();
    chk("R10 abort reset", {31'd0, abort}, 0);
    rd(5'd16, v); chk("R1 chan word reset", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule